// File: doc/BRIEF.md
# Multi-Hit Ring-Delay Time Digitizer

This block turns the arrival times of up to four pulses on a single hit input into 12-bit time codes. Its finest unit is the delay of one stage of a free-running gate ring that sits outside the block. The ring reaches the block only as a tap vector, which shows the ring's instantaneous state, and a lap tick, which marks each completed revolution. A measurement opens on a start strobe. From then on a lap counter counts revolutions. Every accepted rising edge on the hit input captures the lap count together with the encoded tap position.

Two edges that come closer together than a programmable number of stage steps are taken as one pulse, so a bouncing or glitching hit never fills a slot with a wrong capture. The stage delay is never tuned. Instead, a calibration path runs all the time and counts how many stage steps fit between successive rising edges of a slow reference clock. Downstream logic uses that count as the scale that turns codes into time.

Top module: `ringtdc_multihit`

## Requirements
- R1: A start strobe clears the hit counter and the slot mask, drops the done flag and arms capture. All of this is visible on the cycle after the strobe.
- R2: A hit code equals 32 × (lap ticks counted on the cycles after the start strobe, up to and including the hit cycle) plus the tap index. The tap index is the lowest bit position i ≥ 1 whose tap differs from tap bit 0, or 0 when all taps are equal. The ring may show either polarity.
- R3: Each accepted rising edge produces a one-cycle `hit_vld_o` on the following cycle. That pulse carries the code and a 2-bit slot index. Slot indices run 0, 1, 2, 3 in order of arrival.
- R4: The first edge of a measurement is always accepted. A later rising edge is ignored when its code minus the last accepted code is less than `merge_win_i`. An edge whose gap is equal to or greater than `merge_win_i` is accepted.
- R5: The fourth accepted hit ends the measurement. `done_o` rises together with that hit's valid pulse, `hit_count_o` reads 4, and later edges produce no valid pulse until the next start.
- R6: A lap tick that arrives while the lap count is 127 ends the measurement with `done_o`. A hit edge in that same cycle is ignored, and `hit_count_o` reports the hits captured before it.
- R7: Bit i of `slot_vld_o` is set only when slot i has been captured. Slots left unused read 0.
- R8: Rising edges on the hit input are ignored when no measurement is armed.
- R9: On each rising reference edge after the first, `cal_o` takes the number of stage steps since the previous rising reference edge. `cal_vld_o` rises on the second rising reference edge and then stays high.
- R10: After reset, `hit_vld_o`, `done_o`, `slot_vld_o` and `cal_vld_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; opens a new measurement |
| hit_i | input | 1 | Hit input; its rising edges are timed |
| merge_win_i | input | 12 | Merge window in stage steps |
| ring_taps_i | input | 32 | Ring tap vector |
| lap_tick_i | input | 1 | High in a cycle in which the ring completed a lap |
| ref_i | input | 1 | Slow reference clock, sampled |
| hit_code_o | output | 12 | Code of the captured hit |
| hit_idx_o | output | 2 | Slot index of the captured hit |
| hit_vld_o | output | 1 | One-cycle valid for a captured hit |
| done_o | output | 1 | Measurement finished |
| hit_count_o | output | 3 | Number of hits captured in the measurement |
| slot_vld_o | output | 4 | Mask of captured slots |
| cal_o | output | 19 | Stage steps per reference period |
| cal_vld_o | output | 1 | Calibration value is valid |

## Verification
The assertions assume that the hit input is a level sampled once per clock. Two rising edges are therefore always separated by at least one low cycle. They also assume that the lap tick marks at most one revolution per cycle. The stimulus advances a model ring by fewer than 32 stages per clock and derives both the taps and the tick from that single position, so these assumptions always hold. Every hit pulse is followed by a low cycle. The reference clock is held low through reset and then toggles slowly, which keeps every calibration interval well inside the 19-bit result.

// File: rtl/ringtdc_pkg.sv
package ringtdc_pkg;

   typedef enum logic [1:0] {
      MEAS_IDLE  = 2'd0,
      MEAS_ARMED = 2'd1,
      MEAS_FIN   = 2'd2
   } meas_state_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ringtdc_tap_enc.sv
module ringtdc_tap_enc #(
   parameter int unsigned NSTAGE = 32,
   localparam int unsigned SW = $clog2(NSTAGE)
) (
   input  logic [NSTAGE-1:0] taps_i,
   output logic [SW-1:0]     pos_o
);

   logic [NSTAGE-1:0] edge_v;

   // mark every stage that disagrees with the first stage
   assign edge_v[0] = 1'b0;
   for (genvar g = 1; g < NSTAGE; g++) begin : g_diff
      assign edge_v[g] = taps_i[g] ^ taps_i[0];
   end

   // lowest disagreeing stage wins: scan downward so it is written last
   always_comb begin
      pos_o = '0;
      for (int i = NSTAGE - 1; i >= 1; i--) begin
         if (edge_v[i]) pos_o = SW'(i);
      end
   end

endmodule

// File: rtl/ringtdc_cal.sv
module ringtdc_cal #(
   parameter int unsigned SW       = 5,
   parameter int unsigned CAL_LAPW = 14,
   localparam int unsigned CALW    = CAL_LAPW + SW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lap_tick_i,
   input  logic [SW-1:0]   pos_i,
   input  logic            ref_i,
   output logic [CALW-1:0] cal_o,
   output logic            cal_vld_o
);

   logic [CAL_LAPW-1:0] lap_q, lap_nxt;
   logic [CALW-1:0]     stamp, prev_stamp;
   logic                ref_d, primed, ref_rise;

   assign lap_nxt  = lap_q + CAL_LAPW'(lap_tick_i);
   assign stamp    = {lap_nxt, pos_i};
   assign ref_rise = ref_i & ~ref_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lap_q      <= '0;
         ref_d      <= 1'b0;
         primed     <= 1'b0;
         prev_stamp <= '0;
         cal_o      <= '0;
         cal_vld_o  <= 1'b0;
      end else begin
         lap_q <= lap_nxt;
         ref_d <= ref_i;
         if (ref_rise) begin
            prev_stamp <= stamp;
            primed     <= 1'b1;
            if (primed) begin
               cal_o     <= stamp - prev_stamp;
               cal_vld_o <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ringtdc_hit_ctrl.sv
module ringtdc_hit_ctrl
   import ringtdc_pkg::*;
#(
   parameter int unsigned SW    = 5,
   parameter int unsigned LAPW  = 7,
   parameter int unsigned NHITS = 4,
   localparam int unsigned CODEW = LAPW + SW,
   localparam int unsigned IW    = idx_width(NHITS),
   localparam int unsigned CNTW  = $clog2(NHITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             hit_i,
   input  logic             lap_tick_i,
   input  logic [SW-1:0]    pos_i,
   input  logic [CODEW-1:0] merge_win_i,
   output logic [CODEW-1:0] hit_code_o,
   output logic [IW-1:0]    hit_idx_o,
   output logic             hit_vld_o,
   output logic             done_o,
   output logic [CNTW-1:0]  hit_count_o,
   output logic [NHITS-1:0] slot_vld_o
);

   meas_state_e       state_q;
   logic [LAPW-1:0]   lap_q, lap_nxt;
   logic [CNTW-1:0]   n_q;
   logic [CODEW-1:0]  last_code, code_now, gap;
   logic [NHITS-1:0]  slot_q;
   logic              hit_d, armed, rise, ovf, far, accept, last_slot;

   assign armed     = (state_q == MEAS_ARMED);
   assign lap_nxt   = lap_q + LAPW'(lap_tick_i);
   assign code_now  = {lap_nxt, pos_i};
   assign gap       = code_now - last_code;
   assign rise      = hit_i & ~hit_d;
   assign ovf       = armed & lap_tick_i & (&lap_q);
   assign far       = (n_q == '0) || (gap >= merge_win_i);
   assign accept    = armed & rise & ~ovf & ~start_i & far;
   assign last_slot = (n_q == CNTW'(NHITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= MEAS_IDLE;
         lap_q      <= '0;
         n_q        <= '0;
         last_code  <= '0;
         slot_q     <= '0;
         hit_d      <= 1'b0;
         hit_vld_o  <= 1'b0;
         hit_code_o <= '0;
         hit_idx_o  <= '0;
      end else begin
         hit_d     <= hit_i;
         hit_vld_o <= accept;
         if (start_i) begin
            state_q   <= MEAS_ARMED;
            lap_q     <= '0;
            n_q       <= '0;
            slot_q    <= '0;
            last_code <= '0;
         end else if (armed) begin
            lap_q <= lap_nxt;
            if (accept) begin
               hit_code_o                <= code_now;
               hit_idx_o                 <= n_q[IW-1:0];
               slot_q[n_q[IW-1:0]]       <= 1'b1;
               n_q                       <= n_q + 1'b1;
               last_code                 <= code_now;
               if (last_slot) state_q    <= MEAS_FIN;
            end
            if (ovf) state_q <= MEAS_FIN;
         end
      end
   end

   assign done_o      = (state_q == MEAS_FIN);
   assign hit_count_o = n_q;
   assign slot_vld_o  = slot_q;

endmodule

// File: rtl/ringtdc_multihit.sv
module ringtdc_multihit
   import ringtdc_pkg::*;
#(
   parameter int unsigned NSTAGE   = 32,
   parameter int unsigned LAPW     = 7,
   parameter int unsigned NHITS    = 4,
   parameter int unsigned CAL_LAPW = 14,
   localparam int unsigned SW    = $clog2(NSTAGE),
   localparam int unsigned CODEW = LAPW + SW,
   localparam int unsigned IW    = idx_width(NHITS),
   localparam int unsigned CNTW  = $clog2(NHITS + 1),
   localparam int unsigned CALW  = CAL_LAPW + SW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              hit_i,
   input  logic [CODEW-1:0]  merge_win_i,
   input  logic [NSTAGE-1:0] ring_taps_i,
   input  logic              lap_tick_i,
   input  logic              ref_i,
   output logic [CODEW-1:0]  hit_code_o,
   output logic [IW-1:0]     hit_idx_o,
   output logic              hit_vld_o,
   output logic              done_o,
   output logic [CNTW-1:0]   hit_count_o,
   output logic [NHITS-1:0]  slot_vld_o,
   output logic [CALW-1:0]   cal_o,
   output logic              cal_vld_o
);

   // elaboration checks on the parameter set
   if (NSTAGE < 2 || NSTAGE != (1 << SW)) begin : g_bad_nstage
      $error("ring stage count must be a power of two of at least 2");
   end
   if (NHITS < 1) begin : g_bad_nhits
      $error("at least one hit slot is required");
   end
   if (CAL_LAPW < LAPW) begin : g_bad_cal
      $error("calibration lap counter narrower than measurement lap counter");
   end

   logic [SW-1:0] tap_pos;

   ringtdc_tap_enc #(.NSTAGE(NSTAGE)) u_enc (
      .taps_i (ring_taps_i),
      .pos_o  (tap_pos)
   );

   ringtdc_hit_ctrl #(.SW(SW), .LAPW(LAPW), .NHITS(NHITS)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .hit_i       (hit_i),
      .lap_tick_i  (lap_tick_i),
      .pos_i       (tap_pos),
      .merge_win_i (merge_win_i),
      .hit_code_o  (hit_code_o),
      .hit_idx_o   (hit_idx_o),
      .hit_vld_o   (hit_vld_o),
      .done_o      (done_o),
      .hit_count_o (hit_count_o),
      .slot_vld_o  (slot_vld_o)
   );

   ringtdc_cal #(.SW(SW), .CAL_LAPW(CAL_LAPW)) u_cal (
      .clk        (clk),
      .rst_n      (rst_n),
      .lap_tick_i (lap_tick_i),
      .pos_i      (tap_pos),
      .ref_i      (ref_i),
      .cal_o      (cal_o),
      .cal_vld_o  (cal_vld_o)
   );

endmodule

// File: rtl/ringtdc_multihit_chk.sv
module ringtdc_multihit_chk #(
   parameter int unsigned NHITS = 4,
   parameter int unsigned IW    = 2,
   parameter int unsigned CNTW  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             hit_vld_o,
   input logic [IW-1:0]    hit_idx_o,
   input logic             done_o,
   input logic [CNTW-1:0]  hit_count_o,
   input logic [NHITS-1:0] slot_vld_o,
   input logic             cal_vld_o
);

   // R1: a start strobe clears the capture bookkeeping on the next cycle
   assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && slot_vld_o == '0 && hit_count_o == '0));

   // R3: a valid pulse lasts one cycle
   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld_o |=> !hit_vld_o);

   // R3: reported slot index is the slot just filled
   assert_idx_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld_o |-> (CNTW'(hit_idx_o) == CNTW'(hit_count_o - 1'b1)));

   // R5: a finished measurement stays finished until restarted
   assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);

   // R5: nothing is captured after the end of a measurement
   assert_no_hit_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !hit_vld_o);

   // R6: the hit count never exceeds the slot count
   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_count_o <= CNTW'(NHITS));

   // R7: the slot mask agrees with the number of captures
   assert_mask_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(slot_vld_o) == int'(hit_count_o));

   // R9: calibration validity is sticky
   assert_cal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cal_vld_o |=> cal_vld_o);

endmodule

bind ringtdc_multihit ringtdc_multihit_chk #(
   .NHITS (NHITS),
   .IW    (IW),
   .CNTW  (CNTW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .hit_vld_o   (hit_vld_o),
   .hit_idx_o   (hit_idx_o),
   .done_o      (done_o),
   .hit_count_o (hit_count_o),
   .slot_vld_o  (slot_vld_o),
   .cal_vld_o   (cal_vld_o)
);

// File: tb/ringtdc_multihit_tb.sv
`timescale 1ns/1ps
module ringtdc_multihit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        hit_i = 1'b0;
   logic [11:0] merge_win_i = '0;
   logic [31:0] ring_taps_i = '0;
   logic        lap_tick_i = 1'b0;
   logic        ref_i = 1'b0;
   logic [11:0] hit_code_o;
   logic [1:0]  hit_idx_o;
   logic        hit_vld_o;
   logic        done_o;
   logic [2:0]  hit_count_o;
   logic [3:0]  slot_vld_o;
   logic [18:0] cal_o;
   logic        cal_vld_o;

   int n_chk = 0;
   int n_bad = 0;
   int pos = 0;
   int pos_start = 0;
   int stepv = 10;
   int ref_cnt = 0;
   int last_rise = 0;
   bit have_rise = 0;
   bit finished = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   ringtdc_multihit u_dut (
      .clk, .rst_n, .start_i, .hit_i, .merge_win_i, .ring_taps_i,
      .lap_tick_i, .ref_i, .hit_code_o, .hit_idx_o, .hit_vld_o,
      .done_o, .hit_count_o, .slot_vld_o, .cal_o, .cal_vld_o
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] taps_of(input int p);
      int ph = p % 32;
      logic [31:0] t = (ph == 0) ? 32'h0 : ((32'h1 << ph) - 32'h1);
      if (((p / 32) % 2) == 1) t = ~t;
      return t;
   endfunction

   // one clock: drive at the falling edge, look just after the rising edge
   task automatic step(input logic h, input logic s);
      int prev;
      bit rise;
      @(negedge clk);
      prev        = pos;
      pos         = pos + stepv;
      ring_taps_i = taps_of(pos);
      lap_tick_i  = ((pos / 32) != (prev / 32));
      hit_i       = h;
      start_i     = s;
      ref_cnt++;
      rise  = (((ref_cnt / 20) % 2) == 1) && !ref_i;
      ref_i = ((ref_cnt / 20) % 2) == 1;
      if (s) pos_start = pos;
      @(posedge clk);
      #1;
      if (rise) begin
         if (have_rise) begin
            chk("R9 cal value", int'(cal_o), (pos - last_rise) % (1 << 19));
            chk("R9 cal valid", int'(cal_vld_o), 1);
         end else begin
            chk("R9 cal not yet valid", int'(cal_vld_o), 0);
         end
         have_rise = 1;
         last_rise = pos;
      end
   endtask

   function automatic int exp_code();
      return pos - (pos_start / 32) * 32;
   endfunction

   task automatic t_reset();
      chk("R10 hit_vld", int'(hit_vld_o), 0);
      chk("R10 done", int'(done_o), 0);
      chk("R10 slot mask", int'(slot_vld_o), 0);
      chk("R10 cal_vld", int'(cal_vld_o), 0);
   endtask

   task automatic t_idle_hits();
      stepv = 9;
      for (int i = 0; i < 3; i++) begin
         step(1'b1, 1'b0);
         chk("R8 idle edge ignored", int'(hit_vld_o), 0);
         step(1'b0, 1'b0);
         chk("R8 idle count", int'(hit_count_o), 0);
      end
   endtask

   task automatic t_four_hits();
      stepv = 13;
      merge_win_i = 12'd8;
      step(1'b0, 1'b1);
      chk("R1 done cleared", int'(done_o), 0);
      chk("R1 mask cleared", int'(slot_vld_o), 0);
      for (int k = 0; k < 4; k++) begin
         for (int j = 0; j < 2 + k; j++) step(1'b0, 1'b0);
         step(1'b1, 1'b0);
         chk("R3 valid pulse", int'(hit_vld_o), 1);
         chk("R2 hit code", int'(hit_code_o), exp_code());
         chk("R3 slot index", int'(hit_idx_o), k);
         chk("R7 slot mask", int'(slot_vld_o), (1 << (k + 1)) - 1);
         chk("R5 done timing", int'(done_o), (k == 3) ? 1 : 0);
         step(1'b0, 1'b0);
         chk("R3 pulse ends", int'(hit_vld_o), 0);
      end
      chk("R5 count", int'(hit_count_o), 4);
      step(1'b1, 1'b0);
      chk("R5 fifth edge ignored", int'(hit_vld_o), 0);
      step(1'b0, 1'b0);
   endtask

   task automatic t_restart();
      stepv = 11;
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      chk("R3 first after start", int'(hit_idx_o), 0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      chk("R1 restart count", int'(hit_count_o), 0);
      chk("R1 restart mask", int'(slot_vld_o), 0);
      step(1'b1, 1'b0);
      chk("R3 index after restart", int'(hit_idx_o), 0);
      chk("R2 code after restart", int'(hit_code_o), exp_code());
      step(1'b0, 1'b0);
   endtask

   task automatic t_merge_ovf();
      int laps;
      bit seen;
      stepv = 10;
      merge_win_i = 12'd40;
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      chk("R4 first edge accepted", int'(hit_vld_o), 1);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);               // gap 20
      chk("R4 close edge merged", int'(hit_vld_o), 0);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);               // gap 40
      chk("R4 gap equal to window", int'(hit_vld_o), 1);
      chk("R4 index after merge", int'(hit_idx_o), 1);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);               // gap 30
      chk("R4 gap below window", int'(hit_vld_o), 0);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);               // gap 50
      chk("R4 wide gap accepted", int'(hit_vld_o), 1);
      chk("R2 code after merge", int'(hit_code_o), exp_code());
      stepv = 31;
      seen = 0;
      for (int i = 0; i < 400 && !seen; i++) begin
         step(1'b0, 1'b0);
         if (done_o) begin
            seen = 1;
            laps = pos / 32 - pos_start / 32;
            chk("R6 overflow lap", laps, 128);
         end
      end
      chk("R6 done on overflow", int'(seen), 1);
      chk("R6 count", int'(hit_count_o), 3);
      chk("R7 partial mask", int'(slot_vld_o), 7);
      step(1'b1, 1'b0);
      chk("R6 edge after overflow", int'(hit_vld_o), 0);
      step(1'b0, 1'b0);
   endtask

   task automatic t_cal();
      stepv = 7;
      for (int i = 0; i < 60; i++) step(1'b0, 1'b0);
      stepv = 23;
      for (int i = 0; i < 60; i++) step(1'b0, 1'b0);
      chk("R9 cal stays valid", int'(cal_vld_o), 1);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_idle_hits();
      t_four_hits();
      t_restart();
      t_merge_ovf();
      t_cal();
      summary();
   end

endmodule